// File: doc/BRIEF.md
# Atomic Micro-op Sequence Expander

This block sits after instruction decode and turns one atomic instruction (load-reserved, store-conditional or read-modify-write) into an ordered stream of one to three micro-ops. The instruction's two ordering bits, acquire and release, decide the shape of the stream. A release request puts a fence in front of the memory micro-op. An acquire request puts a fence after it. With neither bit set, the stream is the memory micro-op alone.

Every emitted micro-op carries a kind code, four sequencing flags (first, last, memory barrier, delayed commit) and three access-class bits (load, store, atomic). It also carries an opaque payload that the block copies unchanged from the instruction. Fences do no architectural work; their flags only tell the later stages how to order and retire the group.

Both sides use a valid/ready handshake. An item moves on a clock edge where valid and ready are both high. The output holds all of its fields while it waits for ready. The input side accepts an instruction only when no sequence is pending, or in the same cycle that the last micro-op of the current sequence is handed off. That second case lets back-to-back instructions flow with no idle cycle.

Top module: `atx_expander`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With aq=0 and rl=0, exactly one micro-op is emitted. It is the core micro-op with first=1, last=1, barrier=0 and dcommit=0.
- R3: With rl=1 and aq=0, two micro-ops are emitted. The first is a fence with first=1, barrier=1, dcommit=1 and last=0. The second is the core micro-op with first=0, last=1, barrier=0 and dcommit=0.
- R4: With aq=1 and rl=0, two micro-ops are emitted. The first is the core micro-op with first=1, last=0, barrier=0 and dcommit=1. The second is a fence with first=0, last=1, barrier=1 and dcommit=0.
- R5: With aq=1 and rl=1, three micro-ops are emitted, in this order:
  - a release fence with first=1, last=0, barrier=1 and dcommit=1;
  - the core micro-op with first=0, last=0, barrier=0 and dcommit=1;
  - an acquire fence with first=0, last=1, barrier=1 and dcommit=0.
- R6: Kind codes are 0 = fence, 1 = load-reserved, 2 = store-conditional and 3 = read-modify-write. The core micro-op's kind equals in_kind. The class bits are set as follows:
  - load-reserved core: load=1, store=0, atomic=0;
  - store-conditional core: store=1, load=0, atomic=0;
  - read-modify-write core: atomic=1, load=0, store=0;
  - fences: load, store and atomic all 0.
- R7: Every micro-op of a sequence carries the payload of the instruction it came from.
- R8: While out_valid=1 and out_ready=0, out_valid stays 1 and every output field holds its value on the next cycle.
- R9: in_ready is 0 while a sequence is pending, except in the cycle where its last micro-op is handed off. An instruction accepted in that cycle drives its first micro-op in the very next cycle.
- R10: An instruction presented while in_ready=0 and withdrawn before in_ready rises is ignored. None of its micro-ops appear on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted on this edge if in_valid |
| in_kind | input | 2 | Instruction kind (1 LR, 2 SC, 3 RMW) |
| in_aq | input | 1 | Acquire ordering bit |
| in_rl | input | 1 | Release ordering bit |
| in_payload | input | PAYLOAD_W | Opaque instruction payload |
| out_valid | output | 1 | Micro-op offered |
| out_ready | input | 1 | Downstream takes the micro-op on this edge |
| out_kind | output | 2 | Micro-op kind code |
| out_first | output | 1 | First micro-op of the group |
| out_last | output | 1 | Last micro-op of the group |
| out_barrier | output | 1 | Memory barrier micro-op |
| out_dcommit | output | 1 | Commit delayed until later group member |
| out_load | output | 1 | Load access class |
| out_store | output | 1 | Store access class |
| out_atomic | output | 1 | Atomic read-modify-write access class |
| out_payload | output | PAYLOAD_W | Payload copied from the instruction |

## Verification
The two functions that can fall in the same cycle are the hand-off of a sequence's last micro-op and the acceptance of the next instruction. The bench provokes this by offering two instructions back to back while out_ready stays high. It then judges that the acceptance edge is the edge of the last hand-off, and that the scoreboard sees the new group's first micro-op with no gap or duplicate. A second run repeats every ordering under an irregular ready pattern, so that accept-at-end and stalled hold are mixed.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [1:0] {
    UK_FENCE = 2'd0,
    UK_LR    = 2'd1,
    UK_SC    = 2'd2,
    UK_AMO   = 2'd3
  } uop_kind_e;

  typedef struct packed {
    uop_kind_e kind;
    logic      first;
    logic      last;
    logic      barrier;
    logic      dcommit;
    logic      is_load;
    logic      is_store;
    logic      is_atomic;
  } uop_tag_t;

  // Slot template: a sequence is a contiguous window of these slots.
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int SLOT_REL  = 0;
  localparam int SLOT_CORE = 1;
  localparam int SLOT_ACQ  = 2;

  function automatic uop_tag_t slot_tag(input int slot, input uop_kind_e core,
                                        input logic aq, input logic rl);
    uop_tag_t t;
    t = '0;
    if (slot == SLOT_REL) begin
      t.kind    = UK_FENCE;
      t.first   = 1'b1;
      t.barrier = 1'b1;
      t.dcommit = 1'b1;
    end else if (slot == SLOT_ACQ) begin
      t.kind    = UK_FENCE;
      t.last    = 1'b1;
      t.barrier = 1'b1;
    end else begin
      t.kind      = core;
      t.first     = ~rl;
      t.last      = ~aq;
      t.dcommit   = aq;
      t.is_load   = (core == UK_LR);
      t.is_store  = (core == UK_SC);
      t.is_atomic = (core == UK_AMO);
    end
    return t;
  endfunction

endpackage

// File: rtl/atx_slot_plan.sv
module atx_slot_plan
  import atx_pkg::*;
(
  input  uop_kind_e         core_kind,
  input  logic              aq,
  input  logic              rl,
  input  logic [SLOT_W-1:0] slot,
  output uop_tag_t          tag,
  output logic [SLOT_W-1:0] end_slot
);

  uop_tag_t tags [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign tags[s] = slot_tag(s, core_kind, aq, rl);
  end

  always_comb begin
    tag = tags[SLOT_CORE];
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot == SLOT_W'(s)) tag = tags[s];
    end
  end

  assign end_slot = aq ? SLOT_W'(SLOT_ACQ) : SLOT_W'(SLOT_CORE);

endmodule

// File: rtl/atx_seq.sv
module atx_seq
  import atx_pkg::*;
#(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_kind,
  input  logic                 in_aq,
  input  logic                 in_rl,
  input  logic [PAYLOAD_W-1:0] in_payload,
  input  logic                 out_ready,
  input  logic [SLOT_W-1:0]    end_slot,
  output logic                 busy,
  output logic [SLOT_W-1:0]    slot,
  output uop_kind_e            kind_q,
  output logic                 aq_q,
  output logic                 rl_q,
  output logic [PAYLOAD_W-1:0] pay_q
);

  logic hs_out, at_end, seq_done, take;

  assign hs_out   = busy & out_ready;
  assign at_end   = (slot == end_slot);
  assign seq_done = hs_out & at_end;
  assign in_ready = ~busy | seq_done;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= SLOT_W'(SLOT_CORE);
      kind_q <= UK_FENCE;
      aq_q   <= 1'b0;
      rl_q   <= 1'b0;
      pay_q  <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      slot   <= in_rl ? SLOT_W'(SLOT_REL) : SLOT_W'(SLOT_CORE);
      kind_q <= uop_kind_e'(in_kind);
      aq_q   <= in_aq;
      rl_q   <= in_rl;
      pay_q  <= in_payload;
    end else if (seq_done) begin
      busy <= 1'b0;
    end else if (hs_out) begin
      slot <= slot + SLOT_W'(1);
    end
  end

  // R8: a stalled micro-op keeps its slot and payload
  a_r8_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready) |=> (busy && $stable(slot) && $stable(pay_q)));

  // R10: nothing is captured while input is refused
  a_r10_refused_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready) |=> ($stable(kind_q) && $stable(aq_q) && $stable(rl_q)));

endmodule

// File: rtl/atx_expander.sv
module atx_expander
  import atx_pkg::*;
#(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_kind,
  input  logic                 in_aq,
  input  logic                 in_rl,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_kind,
  output logic                 out_first,
  output logic                 out_last,
  output logic                 out_barrier,
  output logic                 out_dcommit,
  output logic                 out_load,
  output logic                 out_store,
  output logic                 out_atomic,
  output logic [PAYLOAD_W-1:0] out_payload
);

  logic              busy, aq_q, rl_q;
  logic [SLOT_W-1:0] slot, end_slot;
  uop_kind_e         kind_q;
  uop_tag_t          tag;

  atx_seq #(.PAYLOAD_W(PAYLOAD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .in_aq     (in_aq),
    .in_rl     (in_rl),
    .in_payload(in_payload),
    .out_ready (out_ready),
    .end_slot  (end_slot),
    .busy      (busy),
    .slot      (slot),
    .kind_q    (kind_q),
    .aq_q      (aq_q),
    .rl_q      (rl_q),
    .pay_q     (out_payload)
  );

  atx_slot_plan u_plan (
    .core_kind(kind_q),
    .aq       (aq_q),
    .rl       (rl_q),
    .slot     (slot),
    .tag      (tag),
    .end_slot (end_slot)
  );

  assign out_valid   = busy;
  assign out_kind    = tag.kind;
  assign out_first   = tag.first;
  assign out_last    = tag.last;
  assign out_barrier = tag.barrier;
  assign out_dcommit = tag.dcommit;
  assign out_load    = tag.is_load;
  assign out_store   = tag.is_store;
  assign out_atomic  = tag.is_atomic;

  // R1: idle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));

  // R9: input is taken while busy only on the last hand-off
  a_r9_accept_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid) |-> (out_ready && out_last));

  // R9: a group ends cleanly when nothing new is taken
  a_r9_drain_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !(in_valid && in_ready)) |=> !out_valid);

  // R3: after a non-last hand-off the group continues, not restarts
  a_r3_continue_group: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && !out_first));

  // R6: read-modify-write core is atomic only
  a_r6_amo_class: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd3) |-> (out_atomic && !out_load && !out_store));

  // R6: barriers are fences without access class
  a_r6_barrier_is_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_barrier) |-> (out_kind == 2'd0 && !out_load && !out_store && !out_atomic));

  // R4: a delayed-commit core is never the end of its group
  a_r4_dcommit_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dcommit && !out_barrier) |-> !out_last);

  // R8: outputs hold under back-pressure
  a_r8_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_first)
      && $stable(out_last) && $stable(out_dcommit) && $stable(out_payload)));

endmodule

// File: tb/sim_atx_expander.sv
module sim_atx_expander;

  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;
  localparam int PW     = 8;
  localparam int VW     = PW + 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_kind = 2'd1;
  logic          in_aq = 1'b0, in_rl = 1'b0;
  logic [PW-1:0] in_payload = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_kind;
  logic          out_first, out_last, out_barrier, out_dcommit;
  logic          out_load, out_store, out_atomic;
  logic [PW-1:0] out_payload;

  int checks = 0, failures = 0, cyc = 0, rmode = 0, rdy_ctr = 0;
  int last_hs_cyc = -1, acc_cyc = -2;
  bit done = 0;

  logic [VW-1:0] exp_q [$];
  string         req_q [$];

  atx_expander #(.PAYLOAD_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_aq(in_aq), .in_rl(in_rl), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_first(out_first), .out_last(out_last), .out_barrier(out_barrier),
    .out_dcommit(out_dcommit), .out_load(out_load), .out_store(out_store),
    .out_atomic(out_atomic), .out_payload(out_payload)
  );

  always #HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    rdy_ctr++;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = (rdy_ctr % 3 != 1);
      default: out_ready = 1'b0;
    endcase
  end

  function automatic logic [VW-1:0] mk(input logic [1:0] k, input logic f, l, b, d,
                                       input logic [PW-1:0] p);
    logic ld, st, at;
    ld = (k == 2'd1); st = (k == 2'd2); at = (k == 2'd3);
    return {k, f, l, b, d, ld, st, at, p};
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard model of the expansion, straight from the requirements.
  task automatic push_exp(input logic [1:0] k, input logic aq, rl,
                          input logic [PW-1:0] p, input string req);
    if (rl) begin exp_q.push_back(mk(2'd0, 1, 0, 1, 1, p)); req_q.push_back(req); end
    exp_q.push_back(mk(k, !rl, !aq, 0, aq, p)); req_q.push_back(req);
    if (aq) begin exp_q.push_back(mk(2'd0, 0, 1, 1, 0, p)); req_q.push_back(req); end
  endtask

  task automatic send(input logic [1:0] k, input logic aq, rl,
                      input logic [PW-1:0] p, input string req);
    bit got;
    push_exp(k, aq, rl, p, req);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_aq = aq; in_rl = rl; in_payload = p;
    got = 0;
    while (!got) begin
      #(HALF-1);
      got = in_ready;
      acc_cyc = cyc;
      @(posedge clk);
      if (!got) @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 500) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compares hand-offs against the queue and checks stall hold.
  logic [VW-1:0] prev_vec;
  bit            prev_stall = 0;
  always begin
    logic [VW-1:0] cur, e;
    string r;
    @(negedge clk);
    #(HALF-1);
    cur = {out_kind, out_first, out_last, out_barrier, out_dcommit,
           out_load, out_store, out_atomic, out_payload};
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && cur == prev_vec, "R8 hold", cur, prev_vec);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected micro-op", cur, '0);
        end else begin
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(cur == e, r, cur, e);
        end
        if (out_last) last_hs_cyc = cyc;
      end
      prev_stall = out_valid && !out_ready;
      prev_vec   = cur;
    end else begin
      prev_stall = 0;
    end
  end

  initial begin
    #(PERIOD * 40000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(HALF-1);
    check(!out_valid, "R1 out_valid", {16'd0, out_valid}, '0);
    check(in_ready, "R1 in_ready", {16'd0, in_ready}, 1);

    // Single orderings with full ready
    send(2'd1, 0, 0, 8'h11, "R2 R6 LR"); idle(); drain();
    send(2'd2, 0, 1, 8'h22, "R3 R6 SC"); idle(); drain();
    send(2'd3, 1, 0, 8'h33, "R4 R6 AMO"); idle(); drain();
    send(2'd3, 1, 1, 8'h44, "R5 R6 AMO"); idle(); drain();
    send(2'd1, 1, 1, 8'hA5, "R5 R7 LR"); idle(); drain();
    send(2'd2, 1, 0, 8'h5A, "R4 R7 SC"); idle(); drain();

    // Back-to-back: accept in the cycle of the last hand-off
    send(2'd3, 0, 0, 8'h01, "R9 R2 first");
    send(2'd2, 0, 0, 8'h02, "R9 R2 second");
    check(acc_cyc == last_hs_cyc, "R9 accept at last hand-off",
          VW'(acc_cyc), VW'(last_hs_cyc));
    send(2'd1, 1, 1, 8'h03, "R9 R5 third");
    send(2'd3, 0, 1, 8'h04, "R9 R3 fourth");
    check(acc_cyc == last_hs_cyc, "R9 accept after three-op group",
          VW'(acc_cyc), VW'(last_hs_cyc));
    idle(); drain();

    // Irregular back-pressure
    rmode = 1;
    for (int i = 0; i < 4; i++) begin
      send(2'(i % 3 + 1), i[0], i[1], 8'(8'h60 + i), "R8 stall");
    end
    idle(); drain();
    rmode = 0;
    repeat (2) @(negedge clk);

    // Refused instruction must leave no trace
    rmode = 2;
    repeat (2) @(negedge clk);
    send(2'd3, 1, 1, 8'h77, "R10 R5 kept");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_kind = 2'd1; in_aq = 0; in_rl = 0; in_payload = 8'hEE;
      #(HALF-1);
      check(!in_ready, "R9 R10 refused while pending", {16'd0, in_ready}, '0);
    end
    idle();
    rmode = 0;
    drain();
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R10 queue drained", VW'(exp_q.size()), '0);
    check(!out_valid, "R10 idle at end", {16'd0, out_valid}, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule